// File: doc/BRIEF.md
# Dual-Law Serial Clock Generator

This block derives the serial clock of an SPI master from the module clock. One configuration word holds two divider settings. An 8-bit value `n` gives a linear even ratio of 2×(n+1). A 4-bit value `n` gives a power-of-two ratio of 2^(n+1). A select bit decides which of the two settings drives the clock.

The generator runs only while `run_en` is high. While it is low, the half-period counter is held at zero and the serial clock rests at the idle level set by `cpol`. After `run_en` rises, the clock toggles once every half period. The first toggle follows the rising edge of `run_en` by exactly one half period.

Every toggle also produces a one-cycle strobe, either `launch_stb` or `sample_stb`, chosen from the clock-phase setting. A shift engine uses these strobes to shift data out and capture data in. Divider fields are taken only at half-period boundaries, so reprogramming during a run never creates a short pulse.

Top module: `spi_sclk_gen`

## Requirements
- R1: With `lin_sel`=1, each half period of `sclk` lasts `lin_div`+1 module-clock cycles, so the full period is 2×(`lin_div`+1) cycles.
- R2: With `lin_sel`=0, each half period of `sclk` lasts 2^`pow_div` cycles, so the full period is 2^(`pow_div`+1) cycles.
- R3: `lin_sel`=1 selects the linear law and `lin_sel`=0 selects the power-of-two law. The same field values give different periods under the two laws.
- R4: The linear setting `lin_div`=0 toggles `sclk` on every module-clock cycle, which is half the module clock.
- R5: In every cycle after a clock edge at which `run_en` is low, `sclk` equals the `cpol` value seen at that edge, and neither strobe is asserted. `cpol` and `cpha` are taken only while the generator is idle.
- R6: Each `sclk` toggle asserts exactly one strobe, for one cycle, in the same cycle that `sclk` changes. Toggles are numbered from 1 for each run. Odd-numbered toggles assert `sample_stb` when `cpha`=0 and `launch_stb` when `cpha`=1; even-numbered toggles assert the other strobe. The two strobes are never high together.
- R7: After `run_en` is first seen high, the first toggle occurs after one full half period H. A low `run_en` in the middle of a half period resets the count, so the next run again waits a full H.
- R8: A change to `lin_sel`, `lin_div` or `pow_div` during a half period leaves that half period at its old length and takes effect from the next half period.
- R9: `pow_div`=15 gives half periods of 32768 cycles (ratio 65536) with no early wrap of the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run_en | input | 1 | Runs the generator while high |
| lin_sel | input | 1 | 1 selects the linear law, 0 the power-of-two law |
| lin_div | input | 8 | Linear divider value n |
| pow_div | input | 4 | Power-of-two divider value n |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | Clock phase: picks which toggle samples and which launches |
| sclk | output | 1 | Serial clock level |
| launch_stb | output | 1 | One-cycle strobe on a launch toggle |
| sample_stb | output | 1 | One-cycle strobe on a sample toggle |

## Verification
The assertions assume that `cpol` and `cpha` are steady while `run_en` is high, and that all inputs are synchronous to `clk`. The bench drives every input shortly after a rising edge, so the generator always samples settled values. It changes the polarity and phase settings only while the generator is idle, and it changes the divider fields both when idle and in the middle of a half period. A behavioural model counts half periods and toggle numbers, and its prediction of `sclk` and both strobes is compared with the design on every cycle.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  typedef enum logic {
    LAW_POW2 = 1'b0,
    LAW_LIN  = 1'b1
  } div_law_e;

  typedef struct packed {
    logic launch;
    logic sample;
  } edge_stb_t;

endpackage

// File: rtl/spi_sclk_len.sv
module spi_sclk_len #(
  parameter int LIN_W  = 8,
  parameter int POW_W  = 4,
  parameter int HALF_W = 16
) (
  input  logic              lin_sel,
  input  logic [LIN_W-1:0]  lin_div,
  input  logic [POW_W-1:0]  pow_div,
  output logic [HALF_W-1:0] half_len
);
  import spi_sclk_pkg::*;

  localparam int POW_N = 1 << POW_W;

  logic [HALF_W-1:0] lin_len;
  logic [HALF_W-1:0] pow_len;
  div_law_e          law;

  assign law     = div_law_e'(lin_sel);
  assign lin_len = HALF_W'(lin_div) + HALF_W'(1);

  // One-hot decode of the exponent gives 2**pow_div without a shifter.
  for (genvar gi = 0; gi < POW_N; gi++) begin : g_pow
    assign pow_len[gi] = (pow_div == POW_W'(gi));
  end
  if (HALF_W > POW_N) begin : g_pow_pad
    assign pow_len[HALF_W-1:POW_N] = '0;
  end

  always_comb begin
    if (law == LAW_LIN) half_len = lin_len;
    else                half_len = pow_len;
  end

  always_comb begin
    AST_POW_ONEHOT: assert ($onehot0(pow_len)); // R2
  end

endmodule

// File: rtl/spi_sclk_cnt.sv
module spi_sclk_cnt #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [HALF_W-1:0] half_len,
  output logic              boundary
);

  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic [HALF_W-1:0] len_q, len_d;
  logic              len_en;

  assign boundary = run_en && (cnt_q == (len_q - HALF_W'(1)));
  // The length is captured while idle and at each half-period boundary only.
  assign len_en   = !run_en || boundary;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_en)       cnt_d = '0;
    else if (boundary) cnt_d = '0;
    else               cnt_d = cnt_q + HALF_W'(1);
  end

  always_comb begin
    len_d = len_q;
    if (len_en) len_d = half_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= HALF_W'(1);
    end else begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_q); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt_q == '0)); // R7

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(len_q)); // R8

endmodule

// File: rtl/spi_sclk_edge.sv
module spi_sclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic cpol,
  input  logic cpha,
  input  logic boundary,
  output logic sclk,
  output logic launch_stb,
  output logic sample_stb
);
  import spi_sclk_pkg::*;

  logic      sclk_q, sclk_d;
  logic      odd_q, odd_d;
  logic      pha_q, pha_d;
  edge_stb_t stb_q, stb_d;
  logic      first_kind;

  // Odd-numbered toggles sample when the phase bit is 0, launch when it is 1.
  assign first_kind = !odd_q;

  always_comb begin
    sclk_d = sclk_q;
    odd_d  = odd_q;
    pha_d  = pha_q;
    stb_d  = '0;
    if (!run_en) begin
      sclk_d = cpol;
      odd_d  = 1'b0;
      pha_d  = cpha;
    end else if (boundary) begin
      sclk_d       = !sclk_q;
      odd_d        = !odd_q;
      stb_d.sample = first_kind ^ pha_q;
      stb_d.launch = !(first_kind ^ pha_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      odd_q  <= 1'b0;
      pha_q  <= 1'b0;
      stb_q  <= '0;
    end else begin
      sclk_q <= sclk_d;
      odd_q  <= odd_d;
      pha_q  <= pha_d;
      stb_q  <= stb_d;
    end
  end

  assign sclk       = sclk_q;
  assign launch_stb = stb_q.launch;
  assign sample_stb = stb_q.sample;

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (sclk_q == $past(cpol))); // R5

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_q.launch && stb_q.sample)); // R6

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q != '0) |=> (stb_q == '0) || $changed(sclk_q)); // R6

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int LIN_W = 8,
  parameter int POW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             lin_sel,
  input  logic [LIN_W-1:0] lin_div,
  input  logic [POW_W-1:0] pow_div,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sclk,
  output logic             launch_stb,
  output logic             sample_stb
);

  localparam int POW_N  = 1 << POW_W;
  localparam int HALF_W = (LIN_W + 1 > POW_N) ? LIN_W + 1 : POW_N;

  logic [HALF_W-1:0] half_len;
  logic              boundary;

  spi_sclk_len #(
    .LIN_W (LIN_W),
    .POW_W (POW_W),
    .HALF_W(HALF_W)
  ) len_i (
    .lin_sel (lin_sel),
    .lin_div (lin_div),
    .pow_div (pow_div),
    .half_len(half_len)
  );

  spi_sclk_cnt #(
    .HALF_W(HALF_W)
  ) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .half_len(half_len),
    .boundary(boundary)
  );

  spi_sclk_edge edge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .cpol      (cpol),
    .cpha      (cpha),
    .boundary  (boundary),
    .sclk      (sclk),
    .launch_stb(launch_stb),
    .sample_stb(sample_stb)
  );

  AST_NO_IDLE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !(launch_stb || sample_stb)); // R5

  AST_TOGGLE_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_en) && (sclk != $past(sclk))) |-> (launch_stb || sample_stb)); // R6

endmodule

// File: tb/spi_sclk_gen_tb_top.sv
module spi_sclk_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n, run_en, lin_sel, cpol, cpha;
  logic [7:0] lin_div;
  logic [3:0] pow_div;
  wire        sclk, launch_stb, sample_stb;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  spi_sclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .lin_sel(lin_sel),
    .lin_div(lin_div), .pow_div(pow_div), .cpol(cpol), .cpha(cpha),
    .sclk(sclk), .launch_stb(launch_stb), .sample_stb(sample_stb)
  );

  // Behavioural reference: half-period length, elapsed cycles, toggle number.
  int   m_len, m_elapsed, m_toggles;
  logic m_sclk, m_l, m_s, m_pha;

  function automatic int want_len();
    if (lin_sel) return int'(lin_div) + 1;
    return 1 << pow_div;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sclk = 1'b0; m_l = 1'b0; m_s = 1'b0; m_pha = 1'b0;
      m_len = 1; m_elapsed = 0; m_toggles = 0;
    end else if (!run_en) begin
      m_sclk = cpol; m_l = 1'b0; m_s = 1'b0; m_pha = cpha;
      m_len = want_len(); m_elapsed = 0; m_toggles = 0;
    end else begin
      m_l = 1'b0; m_s = 1'b0;
      m_elapsed++;
      if (m_elapsed == m_len) begin
        m_elapsed = 0;
        m_toggles++;
        m_sclk = !m_sclk;
        if ((m_toggles % 2 == 1) != m_pha) m_s = 1'b1;
        else                               m_l = 1'b1;
        m_len = want_len();
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if ({sclk, launch_stb, sample_stb} !== {m_sclk, m_l, m_s}) begin
        n_fail++;
        $display("FAIL R3 cycle model mismatch actual=%b expected=%b",
                 {sclk, launch_stb, sample_stb}, {m_sclk, m_l, m_s});
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic sel, input int ln, input int pn,
                     input logic pol, input logic pha);
    @(posedge clk); #2;
    lin_sel = sel; lin_div = 8'(ln); pow_div = 4'(pn); cpol = pol; cpha = pha;
  endtask

  task automatic set_run(input logic v);
    @(posedge clk); #2 run_en = v;
    @(negedge clk);
  endtask

  // Counts negedges until sclk toggles; reports strobes seen at that toggle.
  task automatic half(output int n, output logic l, output logic s);
    logic p;
    p = sclk; n = 0;
    do begin
      @(negedge clk); n++;
    end while (sclk == p && n < 70000);
    l = launch_stb; s = sample_stb;
  endtask

  int   n;
  logic l, s;

  initial begin
    #1_900_000;
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; lin_sel = 1'b1; lin_div = '0; pow_div = '0;
    cpol = 1'b0; cpha = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 reset idle sclk", int'(sclk), 0);
    chk("R5 reset no strobe", int'(launch_stb | sample_stb), 0);

    // R4: n=0 linear toggles every cycle
    cfg(1'b1, 0, 0, 1'b0, 1'b0);
    set_run(1'b1);
    half(n, l, s); chk("R4 first half n=0", n, 1);
    half(n, l, s); chk("R4 second half n=0", n, 1);
    set_run(1'b0);

    // R1 + R6 with cpha=0
    cfg(1'b1, 5, 3, 1'b0, 1'b0);
    set_run(1'b1);
    half(n, l, s); chk("R1 lin half n=5", n, 6);
    chk("R6 cpha0 odd toggle samples", int'(s), 1);
    chk("R6 cpha0 odd toggle no launch", int'(l), 0);
    half(n, l, s); chk("R1 lin second half", n, 6);
    chk("R6 cpha0 even toggle launches", int'(l), 1);
    set_run(1'b0);

    // R3: same fields, power law selected
    cfg(1'b0, 5, 3, 1'b0, 1'b0);
    set_run(1'b1);
    half(n, l, s); chk("R3 pow law with same fields", n, 8);
    set_run(1'b0);

    // R2 + R6 with cpha=1
    cfg(1'b0, 0, 2, 1'b0, 1'b1);
    set_run(1'b1);
    half(n, l, s); chk("R2 pow half n=2", n, 4);
    chk("R6 cpha1 odd toggle launches", int'(l), 1);
    half(n, l, s); chk("R2 pow second half", n, 4);
    chk("R6 cpha1 even toggle samples", int'(s), 1);
    set_run(1'b0);

    // R5 idle high, R7 first toggle timing
    cfg(1'b1, 2, 0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk("R5 idle level cpol=1", int'(sclk), 1);
    set_run(1'b1);
    half(n, l, s); chk("R7 first toggle after H", n, 3);
    chk("R7 first toggle leaves idle", int'(sclk), 0);
    // R7: stop mid-half, restart waits full H
    repeat (1) @(negedge clk);
    set_run(1'b0);
    @(negedge clk);
    chk("R5 stop returns to idle", int'(sclk), 1);
    set_run(1'b1);
    half(n, l, s); chk("R7 restart waits full H", n, 3);
    set_run(1'b0);

    // R8: field change mid-half
    cfg(1'b1, 7, 0, 1'b0, 1'b0);
    set_run(1'b1);
    fork
      half(n, l, s);
      begin repeat (3) @(posedge clk); #2 lin_div = 8'd1; end
    join
    chk("R8 current half keeps old length", n, 8);
    half(n, l, s); chk("R8 new length from next half", n, 2);
    set_run(1'b0);

    // R9: maximum power setting
    cfg(1'b0, 0, 15, 1'b0, 1'b0);
    set_run(1'b1);
    half(n, l, s); chk("R9 pow15 first half", n, 32768);
    half(n, l, s); chk("R9 pow15 second half", n, 32768);
    set_run(1'b0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule